// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Dead Time and Shutdown

This block sits between a modulator's two switch commands and the gate drivers of one half-bridge leg. It receives an already filtered command for the upper switch and one for the lower switch, a filtered shutdown level, and one supply-good flag per switch. It produces two registered gate enables that never overlap. When one enable falls, the opposite enable must wait a programmed number of clock cycles with both enables off. Commands that already leave a wider gap pass through with only the one-cycle register latency.

Protection works at three levels. If both commands are high together, both enables are blanked. While shutdown is high, both enables are forced off. After shutdown clears, a command that stayed high is not honoured again until that command falls and rises once more. A low supply-good flag holds only its own channel off.

The minimum off time `DEAD_CYC` is set in clock cycles and must be at least 2. At a 50 MHz clock the default of 20 gives 400 ns.

Top module: `hb_gate_ctrl`

## Requirements
- R1: During reset and in the first sample after it, both enables are 0. The dead-time window counts as already expired, so a high `cmd_hi` applied after reset raises `gate_hi` one clock later.
- R2: Suppose one enable falls and the opposite command is present, or arrives, fewer than `DEAD_CYC` cycles later. The opposite enable then rises on the `DEAD_CYC`-th clock edge after the fall, which leaves exactly `DEAD_CYC` sampled cycles with both enables at 0.
- R3: Suppose the opposite command rises `G` cycles after the fall, with `G >= DEAD_CYC`. The opposite enable then rises on the first clock edge after that command, so the both-off interval is exactly `G` cycles and no delay is added.
- R4: `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R5: While `cmd_hi` and `cmd_lo` are both 1, both enables go to 0 on the next edge. Once one command drops, the enable that remains is subject to the R2 dead time, counted from the edge on which the blanked enable fell.
- R6: A cycle with `shut` = 1 forces both enables to 0 on the next edge.
- R7: After `shut` returns to 0, a command that stayed high keeps its enable at 0. The enable rises again one edge after that command next goes from 0 to 1 while `shut` is 0.
- R8: `hs_good` = 0 holds `gate_hi` at 0 from the next edge, and `ls_good` = 0 does the same for `gate_lo`. Each flag affects only its own channel. When the flag returns to 1, a command that is still high is honoured again at the next edge.
- R9: An enable that falls and is commanded on again on its own side is not delayed by the dead time. It rises one edge after its command returns.
- R10: An enable is 0 in the cycle after its command was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_hi | input | 1 | Filtered command for the upper switch, 1 = on |
| cmd_lo | input | 1 | Filtered command for the lower switch, 1 = on |
| shut | input | 1 | Filtered shutdown level, 1 = force both off |
| hs_good | input | 1 | Upper-channel supply good, 1 = supply adequate |
| ls_good | input | 1 | Lower-channel supply good, 1 = supply adequate |
| gate_hi | output | 1 | Registered upper gate enable |
| gate_lo | output | 1 | Registered lower gate enable |

## Verification
A corrupted gap counter or off-side mask shows up at the ports on the first cross-over that follows. The opposite enable then rises one or more edges earlier or later than `DEAD_CYC` after the fall. Measuring the both-off run for a zero gap, a short gap, a gap equal to the dead time and a longer gap therefore pins the count exactly. A stuck re-arm flag shows up in the first sample after shutdown clears: either the enable returns while its command is still held high, or it fails to return one edge after a fresh rising edge of the command. Blanking and supply-good faults show up one edge after the offending input pattern.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  localparam int CH_HI = 0;
  localparam int CH_LO = 1;
  localparam int N_CH  = 2;

  // Index of the complementary switch in the same leg.
  function automatic int partner(input int ch);
    return (ch == CH_HI) ? CH_LO : CH_HI;
  endfunction

  // Bits needed for a saturating counter that reaches d.
  function automatic int gap_bits(input int unsigned d);
    return (d < 2) ? 1 : $clog2(d + 1);
  endfunction

endpackage

// File: rtl/hbg_rearm.sv
module hbg_rearm (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd,
  input  logic shut,
  input  logic good,
  output logic req
);

  logic cmd_q;
  logic armed_q;
  logic rise_evt;
  logic armed_eff;

  // Shutdown disarms the channel. Only a fresh 0->1 command edge
  // seen while shutdown is low arms it again.
  assign rise_evt  = cmd & ~cmd_q;
  assign armed_eff = ~shut & (armed_q | rise_evt);
  assign req       = cmd & armed_eff & good;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      cmd_q   <= cmd;
      armed_q <= armed_eff;
    end
  end

endmodule

// File: rtl/hbg_deadtime.sv
module hbg_deadtime
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] fall_evt,
  output logic [N_CH-1:0] permit
);

  localparam int GW = gap_bits(DEAD_CYC);
  localparam logic [GW-1:0] GAP_MAX = GW'(DEAD_CYC);

  logic [GW-1:0]   gap_q;
  logic [N_CH-1:0] off_mask_q;
  logic            expired;
  logic            any_fall;

  // A fall restarts the count at 1 so that exactly DEAD_CYC edges
  // separate the fall from the earliest opposite turn-on.
  function automatic logic [GW-1:0] gap_step(input logic [GW-1:0] cur,
                                             input logic restart);
    if (restart)             return GW'(1);
    else if (cur >= GAP_MAX) return GAP_MAX;
    else                     return cur + GW'(1);
  endfunction

  assign any_fall = |fall_evt;
  assign expired  = (gap_q == GAP_MAX);

  generate
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_permit
      localparam int OTH = partner(ch);
      // A channel is blocked only when its partner is the one that fell last.
      assign permit[ch] = expired | ~off_mask_q[OTH];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q      <= GAP_MAX;
      off_mask_q <= '0;
    end else begin
      gap_q <= gap_step(gap_q, any_fall);
      if (any_fall) off_mask_q <= fall_evt;
    end
  end

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_hi,
  input  logic cmd_lo,
  input  logic shut,
  input  logic hs_good,
  input  logic ls_good,
  output logic gate_hi,
  output logic gate_lo
);

  logic [N_CH-1:0] cmd_v;
  logic [N_CH-1:0] good_v;
  logic [N_CH-1:0] req;
  logic [N_CH-1:0] want;
  logic [N_CH-1:0] permit;
  logic [N_CH-1:0] gate_q;
  logic [N_CH-1:0] gate_nxt;
  logic [N_CH-1:0] fall_evt;
  logic            overlap;

  assign cmd_v[CH_HI]  = cmd_hi;
  assign cmd_v[CH_LO]  = cmd_lo;
  assign good_v[CH_HI] = hs_good;
  assign good_v[CH_LO] = ls_good;

  // Conflicting commands blank both channels.
  assign overlap = &cmd_v;
  assign want    = req & {N_CH{~overlap}};

  generate
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      localparam int OTH = partner(ch);

      hbg_rearm u_rearm (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd_v[ch]),
        .shut  (shut),
        .good  (good_v[ch]),
        .req   (req[ch])
      );

      assign gate_nxt[ch] = want[ch] & ~gate_q[OTH] & permit[ch];
    end
  endgenerate

  assign fall_evt = gate_q & ~gate_nxt;

  hbg_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dt (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_evt (fall_evt),
    .permit   (permit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= '0;
    else        gate_q <= gate_nxt;
  end

  assign gate_hi = gate_q[CH_HI];
  assign gate_lo = gate_q[CH_LO];

endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
  parameter int unsigned DEAD_CYC = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_hi,
  input logic       cmd_lo,
  input logic       shut,
  input logic       hs_good,
  input logic       ls_good,
  input logic       gate_hi,
  input logic       gate_lo,
  input logic       overlap,
  input logic [1:0] fall_evt
);

  // Independent age of the most recent fall, counted in edges.
  int unsigned age;
  logic hi_fell, lo_fell;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age     <= DEAD_CYC;
      hi_fell <= 1'b0;
      lo_fell <= 1'b0;
    end else if (|fall_evt) begin
      age     <= 0;
      hi_fell <= fall_evt[0];
      lo_fell <= fall_evt[1];
    end else if (age < DEAD_CYC) begin
      age <= age + 1;
    end
  end

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  a_r2_lo_waits: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_lo) && hi_fell) |-> (age >= DEAD_CYC));

  a_r2_hi_waits: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) && lo_fell) |-> (age >= DEAD_CYC));

  a_r5_blank: assert property (@(posedge clk) disable iff (!rst_n)
    overlap |=> (!gate_hi && !gate_lo));

  a_r6_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    shut |=> (!gate_hi && !gate_lo));

  a_r8_hs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_good |=> !gate_hi);

  a_r8_ls_supply: assert property (@(posedge clk) disable iff (!rst_n)
    !ls_good |=> !gate_lo);

  a_r10_hi_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_hi |=> !gate_hi);

  a_r10_lo_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_lo |=> !gate_lo);

endmodule

bind hb_gate_ctrl hbg_checker #(.DEAD_CYC(DEAD_CYC)) u_hbg_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_hi   (cmd_hi),
  .cmd_lo   (cmd_lo),
  .shut     (shut),
  .hs_good  (hs_good),
  .ls_good  (ls_good),
  .gate_hi  (gate_hi),
  .gate_lo  (gate_lo),
  .overlap  (overlap),
  .fall_evt (fall_evt)
);

// File: tb/tb_hb_gate_ctrl.sv
module tb_hb_gate_ctrl;

  localparam int D = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_hi = 1'b0, cmd_lo = 1'b0, shut = 1'b0;
  logic hs_good = 1'b1, ls_good = 1'b1;
  wire  gate_hi, gate_lo;

  always #10 clk = ~clk;

  hb_gate_ctrl #(.DEAD_CYC(D)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .shut(shut), .hs_good(hs_good), .ls_good(ls_good),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  int total = 0, bad = 0, both_off = 0, wd = 0;
  string tag = "R1";

  // Behavioural reference: event times and flags, not counters.
  logic m_gh = 0, m_gl = 0, arm_h = 1, arm_l = 1, pc_h = 0, pc_l = 0;
  logic mk_h = 0, mk_l = 0;
  int   edge_n = 0, last_fall = -1000;

  task automatic model_step();
    logic eh, el, wh, wl, ok, nh, nl, fh, fl;
    eh = !shut && (arm_h || (cmd_hi && !pc_h));
    el = !shut && (arm_l || (cmd_lo && !pc_l));
    wh = cmd_hi && eh && hs_good && !(cmd_hi && cmd_lo);
    wl = cmd_lo && el && ls_good && !(cmd_hi && cmd_lo);
    ok = (edge_n - last_fall) >= D;
    nh = wh && !m_gl && (ok || !mk_l);
    nl = wl && !m_gh && (ok || !mk_h);
    fh = m_gh && !nh;
    fl = m_gl && !nl;
    if (fh || fl) begin last_fall = edge_n; mk_h = fh; mk_l = fl; end
    m_gh = nh; m_gl = nl; arm_h = eh; arm_l = el;
    pc_h = cmd_hi; pc_l = cmd_lo;
    edge_n++;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk); #1;
    total++;
    if (gate_hi !== m_gh || gate_lo !== m_gl) begin
      bad++;
      $display("FAIL %s: gates hi/lo=%b%b expected %b%b at edge %0d",
               tag, gate_hi, gate_lo, m_gh, m_gl, edge_n);
    end
    if (!gate_hi && !gate_lo) both_off++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic check(input string r, input int got, input int exp,
                       input string what);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: %s got %0d expected %0d", r, what, got, exp);
    end
  endtask

  // Upper on and settled; lower commanded g cycles after upper drops.
  task automatic gap_test(input int g, input string r);
    int lim;
    tag = r;
    cmd_lo = 1'b0; cmd_hi = 1'b1; run(2 * D + 2);
    cmd_hi = 1'b0; both_off = 0;
    for (int i = 0; i < g; i++) cyc();
    cmd_lo = 1'b1;
    lim = 0;
    while (!gate_lo && lim < 4 * D + g) begin cyc(); lim++; end
    check(r, both_off, (g > D) ? g : D, "both-off cycles");
    cmd_lo = 1'b0; run(D + 2);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      bad++;
      $display("FAIL watchdog: run did not end, got %0d cycles expected fewer", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk); #1;
    check("R1", gate_hi, 0, "gate_hi in reset");
    check("R1", gate_lo, 0, "gate_lo in reset");
    rst_n = 1'b1;
    tag = "R1";
    cmd_hi = 1'b1; cyc();
    check("R1", gate_hi, 1, "gate_hi one edge after reset, window expired");
    run(D + 2);

    // R2 / R3: gap sweep
    gap_test(0, "R2");
    gap_test(2, "R2");
    gap_test(D, "R3");
    gap_test(D + 4, "R3");

    // R9: same-side re-turn-on
    tag = "R9";
    cmd_hi = 1'b1; run(D + 2);
    cmd_hi = 1'b0; cyc();
    check("R9", gate_hi, 0, "gate_hi after drop");
    cmd_hi = 1'b1; cyc();
    check("R9", gate_hi, 1, "gate_hi immediate return");

    // R5: overlap blanking, then dead time from blank edge
    tag = "R5";
    cmd_hi = 1'b0; run(D + 2);
    cmd_lo = 1'b1; run(2);
    cmd_hi = 1'b1; cyc();
    check("R5", gate_lo + gate_hi, 0, "both off on overlap");
    cmd_lo = 1'b0; run(D - 1);
    check("R5", gate_hi, 0, "gate_hi still held by dead time");
    cyc();
    check("R5", gate_hi, 1, "gate_hi after dead time");

    // R6 / R7: shutdown and edge re-arm
    tag = "R6";
    run(3);
    shut = 1'b1; cyc();
    check("R6", gate_hi, 0, "gate_hi under shutdown");
    run(3);
    tag = "R7";
    shut = 1'b0; run(D + 3);
    check("R7", gate_hi, 0, "held command stays suppressed");
    cmd_hi = 1'b0; cyc();
    cmd_hi = 1'b1; cyc();
    check("R7", gate_hi, 1, "resume on fresh edge");

    // R8: per-channel supply good
    tag = "R8";
    hs_good = 1'b0; cyc();
    check("R8", gate_hi, 0, "gate_hi with hs_good low");
    hs_good = 1'b1; cyc();
    check("R8", gate_hi, 1, "gate_hi back with hs_good");
    cmd_hi = 1'b0; run(D + 2);
    ls_good = 1'b0; cmd_lo = 1'b1; run(3);
    check("R8", gate_lo, 0, "gate_lo with ls_good low");
    ls_good = 1'b1; cyc();
    check("R8", gate_lo, 1, "gate_lo back with ls_good");

    // R4 / R10: mixed stimulus against the model every clock
    tag = "R4";
    for (int i = 0; i < 3000; i++) begin
      cmd_hi  = ($urandom_range(0, 3) != 0) ? cmd_hi : ~cmd_hi;
      cmd_lo  = ($urandom_range(0, 3) != 0) ? cmd_lo : ~cmd_lo;
      shut    = ($urandom_range(0, 40) == 0);
      hs_good = ($urandom_range(0, 30) != 0);
      ls_good = ($urandom_range(0, 30) != 0);
      cyc();
      if (gate_hi && gate_lo) check("R4", 1, 0, "both enables high");
    end
    tag = "R10";
    shut = 1'b0; hs_good = 1'b1; ls_good = 1'b1;
    cmd_hi = 1'b0; cmd_lo = 1'b0; cyc();
    check("R10", gate_hi + gate_lo, 0, "enables follow low commands");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule